// File: doc/BRIEF.md
# Memory chip-select unit

This block sits beside a small embedded processor's bus interface. It decodes each memory-cycle address and drives active-low chip selects for two windows. The lower window always starts at address zero and covers a power-of-two size of up to 512 KB. The midrange window has a programmable base and a programmable power-of-two size. Its four selects each cover one quarter of the window. A collapse bit makes select 0 cover the whole midrange window. Selects 1 to 3 then go quiet and are reported as free for general-purpose use.

Software programs the unit through a small write port with three registers. For each select the unit also reports whether its region is an 8-bit or a 16-bit bus, so the bus interface can size the transfer. The outputs are registered on the processor clock. A three-state machine sequences them: ST_IDLE (no select driven), ST_SELECT (one select driven from the latched decode) and ST_HOLD (bus held by another master, all selects high). On every clock the next state is chosen as follows. Bus hold goes to ST_HOLD. Otherwise a strobed memory cycle that hits a window goes to ST_SELECT. Anything else goes to ST_IDLE. That gives the transitions IDLE→SELECT, SELECT→SELECT, SELECT→IDLE, any→HOLD and HOLD→IDLE/SELECT.

Top module: `memcs_unit`

## Requirements
- R1: After reset every select output is high, `width16` is 0 and `gpio_free` is 3'b000.
- R2: The lower select stays high until register index 0 has been written. The midrange selects stay high until register index 2 has been written.
- R3: Writing index 0 sets the lower size to 2^k bytes, with k = `wr_data[4:0]` clamped to 10..19. `lcs_n` asserts for a strobed memory cycle when `addr < 2^k`.
- R4: Index 1 holds the midrange base (`wr_data` whole). Index 2 sets the midrange exponent m = `wr_data[4:0]`, clamped to 10..ADDR_W-1. The window is hit when `addr >> m` equals `base >> m`.
- R5: Within a hit midrange window, `mcs_n[i]` asserts with i = `addr[m-1:m-2]`. At most one select is ever low.
- R6: When index-2 bit 5 (collapse) is set, `mcs_n[0]` covers the whole window, `mcs_n[3:1]` never assert, and `gpio_free` reads 3'b111.
- R7: When an address hits both windows, only the lower select asserts.
- R8: While `bus_hold` is high, all selects are high in the following cycle.
- R9: With `mem_strobe` low (I/O or idle cycle), no select asserts.
- R10: A select reflects the inputs sampled at a rising clock edge and changes only after that edge.
- R11: `width16` equals the width flag of the asserted select and is 0 when none asserts. The lower flag is index-0 bit 5. The flag for `mcs_n[i]` is index-2 bit 6+i, and bit 6 applies in collapse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 2 | Register index: 0 lower, 1 mid base, 2 mid control |
| wr_data | input | ADDR_W | Write data |
| mem_strobe | input | 1 | High for a memory bus cycle |
| bus_hold | input | 1 | Bus granted to another master |
| addr | input | ADDR_W | Bus address |
| lcs_n | output | 1 | Lower window select, active low |
| mcs_n | output | 4 | Midrange sub-selects, active low |
| width16 | output | 1 | Width flag of the asserted select (1 = 16-bit) |
| gpio_free | output | 3 | Selects 1..3 free for general-purpose use |

## Verification
The checker watches four properties on every cycle:
- hold and unstrobed cycles give all-high selects on the next cycle;
- no more than one select is ever low;
- the width flag is zero whenever no select is driven;
- no upper midrange select is driven once collapse has been in force for a cycle.

The address arithmetic can only be shown by the bench's sweeps over several programmed configurations. That covers the size clamping, the sub-region index, lower-window priority on overlap and the per-select width flags. The same holds for the one-cycle output timing and the disabled state before configuration.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_HOLD   = 2'd2
    } cs_state_e;

    localparam logic [1:0] REG_LOWER    = 2'd0;
    localparam logic [1:0] REG_MID_BASE = 2'd1;
    localparam logic [1:0] REG_MID_CTRL = 2'd2;

    localparam int NUM_MID = 4;
    localparam int EXP_W   = 5;
    localparam int SEL_W   = NUM_MID + 1;
endpackage

// File: rtl/memcs_cfg.sv
module memcs_cfg
    import memcs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int MIN_EXP     = 10,
    parameter int LOW_MAX_EXP = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_idx,
    input  logic [ADDR_W-1:0]    wr_data,
    output logic                 low_en,
    output logic [EXP_W-1:0]     low_exp,
    output logic                 low_w16,
    output logic                 mid_en,
    output logic [ADDR_W-1:0]    mid_base,
    output logic [EXP_W-1:0]     mid_exp,
    output logic                 mid_coll,
    output logic [NUM_MID-1:0]   mid_w16
);
    localparam int MID_MAX_EXP = ADDR_W - 1;
    localparam int FLAG_LSB    = EXP_W + 1;

    function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] v,
                                                   input int lo, input int hi);
        if (int'(v) < lo)      return EXP_W'(lo);
        else if (int'(v) > hi) return EXP_W'(hi);
        else                   return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_en   <= 1'b0;
            low_exp  <= EXP_W'(MIN_EXP);
            low_w16  <= 1'b0;
            mid_en   <= 1'b0;
            mid_base <= '0;
            mid_exp  <= EXP_W'(MIN_EXP);
            mid_coll <= 1'b0;
            mid_w16  <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                REG_LOWER: begin
                    low_exp <= clamp_exp(wr_data[EXP_W-1:0], MIN_EXP, LOW_MAX_EXP);
                    low_w16 <= wr_data[EXP_W];
                    low_en  <= 1'b1;
                end
                REG_MID_BASE: mid_base <= wr_data;
                REG_MID_CTRL: begin
                    mid_exp  <= clamp_exp(wr_data[EXP_W-1:0], MIN_EXP, MID_MAX_EXP);
                    mid_coll <= wr_data[EXP_W];
                    mid_w16  <= wr_data[FLAG_LSB +: NUM_MID];
                    mid_en   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/memcs_decode.sv
module memcs_decode
    import memcs_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                low_en,
    input  logic [EXP_W-1:0]    low_exp,
    input  logic                low_w16,
    input  logic                mid_en,
    input  logic [ADDR_W-1:0]   mid_base,
    input  logic [EXP_W-1:0]    mid_exp,
    input  logic                mid_coll,
    input  logic [NUM_MID-1:0]  mid_w16,
    output logic [SEL_W-1:0]    hit,
    output logic                hit_w16
);
    localparam int SUB_W = $clog2(NUM_MID);

    logic              low_hit;
    logic              mid_hit;
    logic [ADDR_W-1:0] sub_shift;
    logic [SUB_W-1:0]  sub_idx;

    always_comb begin
        low_hit   = low_en && ((addr >> low_exp) == '0);
        mid_hit   = mid_en && ((addr >> mid_exp) == (mid_base >> mid_exp));
        sub_shift = addr >> (mid_exp - EXP_W'(SUB_W));
        sub_idx   = mid_coll ? '0 : sub_shift[SUB_W-1:0];
    end

    assign hit[NUM_MID] = low_hit;

    for (genvar i = 0; i < NUM_MID; i++) begin : g_mid_sel
        assign hit[i] = mid_hit && !low_hit && (sub_idx == SUB_W'(i));
    end

    always_comb begin
        if (low_hit)      hit_w16 = low_w16;
        else if (mid_hit) hit_w16 = mid_w16[sub_idx];
        else              hit_w16 = 1'b0;
    end
endmodule

// File: rtl/memcs_fsm.sv
module memcs_fsm
    import memcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mem_strobe,
    input  logic               bus_hold,
    input  logic [SEL_W-1:0]   hit,
    input  logic               hit_w16,
    output logic               lcs_n,
    output logic [NUM_MID-1:0] mcs_n,
    output logic               width16
);
    cs_state_e        state_q, state_d;
    logic [SEL_W-1:0] hit_q;
    logic             w16_q;

    always_comb begin
        if (bus_hold)                state_d = ST_HOLD;
        else if (mem_strobe && |hit) state_d = ST_SELECT;
        else                         state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= '0;
            w16_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hit_q   <= (state_d == ST_SELECT) ? hit : '0;
            w16_q   <= (state_d == ST_SELECT) ? hit_w16 : 1'b0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SELECT: begin
                lcs_n   = ~hit_q[NUM_MID];
                mcs_n   = ~hit_q[NUM_MID-1:0];
                width16 = w16_q;
            end
            ST_IDLE, ST_HOLD: begin
                lcs_n   = 1'b1;
                mcs_n   = '1;
                width16 = 1'b0;
            end
            default: begin
                lcs_n   = 1'b1;
                mcs_n   = '1;
                width16 = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/memcs_unit.sv
module memcs_unit
    import memcs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int MIN_EXP     = 10,
    parameter int LOW_MAX_EXP = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_idx,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic               mem_strobe,
    input  logic               bus_hold,
    input  logic [ADDR_W-1:0]  addr,
    output logic               lcs_n,
    output logic [3:0]         mcs_n,
    output logic               width16,
    output logic [2:0]         gpio_free
);
    logic               low_en, low_w16, mid_en, mid_coll, hit_w16;
    logic [EXP_W-1:0]   low_exp, mid_exp;
    logic [ADDR_W-1:0]  mid_base;
    logic [NUM_MID-1:0] mid_w16;
    logic [SEL_W-1:0]   hit;

    memcs_cfg #(.ADDR_W(ADDR_W), .MIN_EXP(MIN_EXP), .LOW_MAX_EXP(LOW_MAX_EXP)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .low_en(low_en), .low_exp(low_exp), .low_w16(low_w16),
        .mid_en(mid_en), .mid_base(mid_base), .mid_exp(mid_exp),
        .mid_coll(mid_coll), .mid_w16(mid_w16)
    );

    memcs_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr(addr), .low_en(low_en), .low_exp(low_exp), .low_w16(low_w16),
        .mid_en(mid_en), .mid_base(mid_base), .mid_exp(mid_exp),
        .mid_coll(mid_coll), .mid_w16(mid_w16), .hit(hit), .hit_w16(hit_w16)
    );

    memcs_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .mem_strobe(mem_strobe), .bus_hold(bus_hold),
        .hit(hit), .hit_w16(hit_w16),
        .lcs_n(lcs_n), .mcs_n(mcs_n), .width16(width16)
    );

    assign gpio_free = {3{mid_coll}};
endmodule

// File: rtl/memcs_unit_chk.sv
module memcs_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_strobe,
    input logic       bus_hold,
    input logic       lcs_n,
    input logic [3:0] mcs_n,
    input logic       width16,
    input logic [2:0] gpio_free
);
    AST_HOLD_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |=> (lcs_n && (&mcs_n))); // R8

    AST_STROBE_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_strobe |=> (lcs_n && (&mcs_n))); // R9

    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{lcs_n, mcs_n})); // R5

    AST_WIDTH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lcs_n && (&mcs_n)) |-> !width16); // R11

    AST_COLLAPSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_free[0] && $past(gpio_free[0])) |-> (&mcs_n[3:1])); // R6
endmodule

bind memcs_unit memcs_unit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mem_strobe(mem_strobe), .bus_hold(bus_hold),
    .lcs_n(lcs_n), .mcs_n(mcs_n), .width16(width16), .gpio_free(gpio_free)
);

// File: tb/memcs_unit_tb.sv
`timescale 1ns/1ps
module memcs_unit_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic          mem_strobe = 1'b0;
    logic          bus_hold = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          lcs_n;
    logic [3:0]    mcs_n;
    logic          width16;
    logic [2:0]    gpio_free;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit      m_low_en = 0, m_low_w = 0, m_mid_en = 0, m_coll = 0;
    int      m_low_k = 0, m_mid_k = 0, m_base = 0;
    bit [3:0] m_mid_w = 0;

    always #5 clk = ~clk;

    memcs_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mem_strobe(mem_strobe), .bus_hold(bus_hold), .addr(addr),
        .lcs_n(lcs_n), .mcs_n(mcs_n), .width16(width16), .gpio_free(gpio_free)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // expected {lcs_n, mcs_n[3:0], width16}
    function automatic logic [5:0] model(int a, bit s, bit h);
        int lk, mk, sub;
        bit lh, mh;
        if (h || !s) return 6'b111110;
        lk = clampi(m_low_k, 10, 19);
        mk = clampi(m_mid_k, 10, AW - 1);
        lh = m_low_en && ((a >> lk) == 0);
        mh = m_mid_en && ((a >> mk) == (m_base >> mk));
        sub = m_coll ? 0 : ((a >> (mk - 2)) & 3);
        if (lh) return {1'b0, 4'hF, m_low_w};
        if (mh) return {1'b1, ~(4'b0001 << sub), m_mid_w[sub]};
        return 6'b111110;
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp, int a);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] idx, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = AW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(string tag, int a, bit s, bit h);
        @(negedge clk);
        addr = AW'(a); mem_strobe = s; bus_hold = h;
        @(negedge clk);
        check(tag, {lcs_n, mcs_n, width16}, model(a, s, h), a);
    endtask

    task automatic sweep(string tag, int step);
        for (int a = 0; a < (1 << AW); a += step) apply(tag, a, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {lcs_n, mcs_n, width16}, 6'b111110, 0);
        check("R1", {3'b000, gpio_free}, 6'b000000, 0);
        rst_n = 1'b1;

        sweep("R2", 32'h4000);

        m_low_en = 1; m_low_k = 14; m_low_w = 1;
        wr(2'd0, 14 | (1 << 5));
        sweep("R2_R3", 32'h400);

        m_base = 32'h40000;
        wr(2'd1, m_base);
        m_mid_en = 1; m_mid_k = 16; m_mid_w = 4'b1010;
        wr(2'd2, 16 | (4'b1010 << 6));
        sweep("R4_R5_R11", 32'h400);

        m_low_k = 25; m_low_w = 0;
        wr(2'd0, 25);
        sweep("R7_R3", 32'h400);

        m_low_k = 3;
        wr(2'd0, 3);
        m_mid_k = 31; m_base = 32'h80000; m_mid_w = 4'b0101;
        wr(2'd1, m_base);
        wr(2'd2, 31 | (4'b0101 << 6));
        sweep("R3_R4", 32'h800);

        m_mid_k = 12; m_base = 32'hC3000; m_coll = 1; m_mid_w = 4'b1110;
        wr(2'd1, m_base);
        wr(2'd2, 12 | (1 << 5) | (4'b1110 << 6));
        @(negedge clk);
        check("R6", {3'b000, gpio_free}, 6'b000111, 0);
        for (int a = 32'hC2000; a < 32'hC5000; a += 32'h100) apply("R6", a, 1'b1, 1'b0);

        m_coll = 0;
        wr(2'd2, 12 | (4'b1110 << 6));
        for (int a = 32'hC3000; a < 32'hC4000; a += 32'h100) apply("R5_R11", a, 1'b1, 1'b0);

        for (int a = 0; a < 32'h1000; a += 32'h200) apply("R8", a, 1'b1, 1'b1);
        apply("R8", 32'hC3800, 1'b1, 1'b1);
        for (int a = 0; a < 32'h1000; a += 32'h200) apply("R9", a, 1'b0, 1'b0);
        apply("R9", 32'hC3C00, 1'b0, 1'b0);

        @(negedge clk);
        addr = AW'(32'hC3400); mem_strobe = 1'b1; bus_hold = 1'b0;
        #2;
        check("R10", {lcs_n, mcs_n, width16}, 6'b111110, 32'hC3400);
        @(negedge clk);
        check("R10", {lcs_n, mcs_n, width16}, model(32'hC3400, 1'b1, 1'b0), 32'hC3400);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule